// File: doc/BRIEF.md
# Batch-Aware DRAM Request Arbiter

This block picks, for every DRAM bank, which entry of a shared memory request buffer should be issued next. Each buffer entry presents a valid flag, a batch-membership flag, a thread id, a target bank, a target row and an arrival sequence number. The block also receives the row now open in each bank and a rank for each thread. Batch formation, rank computation and DRAM command timing are handled elsewhere and arrive only as inputs.

Every clock cycle the block compares all candidates of each bank with one fixed key. The key levels, from most to least important, are:

1. Batch membership.
2. Row-buffer hit.
3. Thread rank.
4. Age.

The winning index and a grant-valid flag for each bank are registered and appear one cycle after the inputs. Every bank reads its ranks from the same table, so a top-ranked thread tends to win in all its banks at once and its requests are served in parallel.

Top module: `batch_req_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every grant-valid bit is 0.
- R2: A grant for bank b names an entry that was valid, with its bank field equal to b, in the inputs of the previous cycle.
- R3: A bank that had no valid entry targeting it in the previous cycle drives its grant-valid low.
- R4: A bank that had at least one valid entry targeting it in the previous cycle drives its grant-valid high. This holds even if none of those entries is marked.
- R5: Among a bank's candidates, a marked entry always wins over an unmarked one.
- R6: Among candidates equal in the marked flag, a row hit wins over a miss. A row hit means the entry's row equals the open row given for its bank.
- R7: Among candidates equal in the levels above, the entry whose thread has the numerically smaller rank wins. Rank 0 is the highest. The same rank table applies to every bank.
- R8: Among candidates equal in the levels above, the entry with the smaller age value wins. Smaller means older, and the age value does not wrap.
- R9: If candidates are still equal after all four levels, the lowest buffer index wins.
- R10: A new decision is registered on every clock edge from the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_ENTRIES | Entry holds a request |
| req_marked | input | NUM_ENTRIES | Entry belongs to the current batch |
| req_thread | input | NUM_ENTRIES*TID_W | Thread id per entry |
| req_bank | input | NUM_ENTRIES*BANK_W | Target bank per entry |
| req_row | input | NUM_ENTRIES*ROW_W | Target row per entry |
| req_age | input | NUM_ENTRIES*AGE_W | Arrival sequence number per entry; smaller is older |
| open_row | input | NUM_BANKS*ROW_W | Row currently open in each bank |
| thread_rank | input | NUM_THREADS*RANK_W | Rank per thread; 0 is the highest |
| grant_valid | output | NUM_BANKS | Bank has a winner this cycle |
| grant_idx | output | NUM_BANKS*IDX_W | Buffer index of each bank's winner |

## Verification
The key levels act in the same cycle and conflict inside one bank. The bench loads a single bank with a marked row miss beside an unmarked row hit. It also loads a hit from a low-rank thread beside a miss from a top-rank thread. It then drives equal keys at two indices and checks that only the intended level decides each case.

The bench also checks rank ordering across banks in the same cycle. One thread is placed in two banks against the same rival, and both banks must choose it.

Random buffers use a small row range so that hits and ties are frequent. Every bank's winner is compared with a bench model that walks the four levels one by one and then falls back to the lowest index.

// File: rtl/batch_req_arbiter.sv
module batch_req_arbiter #(
  parameter int NUM_ENTRIES = 128,
  parameter int NUM_BANKS   = 8,
  parameter int NUM_THREADS = 8,
  parameter int ROW_W       = 14,
  parameter int AGE_W       = 16,
  parameter int RANK_W      = 3,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int TID_W  = $clog2(NUM_THREADS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_ENTRIES-1:0]        req_valid,
  input  logic [NUM_ENTRIES-1:0]        req_marked,
  input  logic [NUM_ENTRIES*TID_W-1:0]  req_thread,
  input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
  input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
  input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
  input  logic [NUM_BANKS*ROW_W-1:0]    open_row,
  input  logic [NUM_THREADS*RANK_W-1:0] thread_rank,
  output logic [NUM_BANKS-1:0]          grant_valid,
  output logic [NUM_BANKS*IDX_W-1:0]    grant_idx
);

  localparam int KEY_W = 2 + RANK_W + AGE_W;

  // Larger key wins: {marked, hit, ~rank, ~age}
  logic [KEY_W-1:0] entry_key [NUM_ENTRIES];

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      logic [BANK_W-1:0] bk;
      logic [TID_W-1:0]  tid;
      logic              hit;
      bk  = req_bank[i*BANK_W +: BANK_W];
      tid = req_thread[i*TID_W +: TID_W];
      hit = req_row[i*ROW_W +: ROW_W] == open_row[bk*ROW_W +: ROW_W];
      entry_key[i] = {req_marked[i], hit,
                      ~thread_rank[tid*RANK_W +: RANK_W],
                      ~req_age[i*AGE_W +: AGE_W]};
    end
  end

  logic [NUM_ENTRIES-1:0]        vld_d, mk_d;
  logic [NUM_ENTRIES*BANK_W-1:0] bank_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_d  <= '0;
      mk_d   <= '0;
      bank_d <= '0;
    end else begin
      vld_d  <= req_valid;
      mk_d   <= req_marked;
      bank_d <= req_bank;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             found;
    logic [IDX_W-1:0] best;
    logic [KEY_W-1:0] best_key;
    logic             gv_q;
    logic [IDX_W-1:0] gi_q;

    always_comb begin
      found    = 1'b0;
      best     = '0;
      best_key = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (req_valid[i] && req_bank[i*BANK_W +: BANK_W] == BANK_W'(b) &&
            (!found || entry_key[i] > best_key)) begin
          found    = 1'b1;
          best     = IDX_W'(i);
          best_key = entry_key[i];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gv_q <= 1'b0;
        gi_q <= '0;
      end else begin
        gv_q <= found;
        gi_q <= best;
      end
    end

    assign grant_valid[b]                 = gv_q;
    assign grant_idx[b*IDX_W +: IDX_W]    = gi_q;

    logic any_d, any_mk_d;
    always_comb begin
      any_d    = 1'b0;
      any_mk_d = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (vld_d[i] && bank_d[i*BANK_W +: BANK_W] == BANK_W'(b)) begin
          any_d    = 1'b1;
          any_mk_d = any_mk_d | mk_d[i];
        end
      end
    end

    // R2
    grant_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gv_q |-> (vld_d[gi_q] && bank_d[gi_q*BANK_W +: BANK_W] == BANK_W'(b)));
    // R3
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_d |-> !gv_q);
    // R4
    work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_d |-> gv_q);
    // R5
    marked_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gv_q && any_mk_d) |-> mk_d[gi_q]);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> grant_valid == '0);

endmodule

// File: tb/batch_req_arbiter_bench.sv
module batch_req_arbiter_bench;
  localparam int N = 128, B = 8, T = 8, ROW_W = 14, AGE_W = 16, RANK_W = 3;
  localparam int IDX_W = 7, BANK_W = 3, TID_W = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [N-1:0]        req_valid, req_marked;
  logic [N*TID_W-1:0]  req_thread;
  logic [N*BANK_W-1:0] req_bank;
  logic [N*ROW_W-1:0]  req_row;
  logic [N*AGE_W-1:0]  req_age;
  logic [B*ROW_W-1:0]  open_row;
  logic [T*RANK_W-1:0] thread_rank;
  logic [B-1:0]        grant_valid;
  logic [B*IDX_W-1:0]  grant_idx;

  bit v[N], m[N];
  int th[N], bk[N], rw[N], ag[N], orow[B], rk[T];
  int checks = 0, errors = 0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i] = v[i];
      req_marked[i] = m[i];
      req_thread[i*TID_W +: TID_W] = TID_W'(th[i]);
      req_bank[i*BANK_W +: BANK_W] = BANK_W'(bk[i]);
      req_row[i*ROW_W +: ROW_W] = ROW_W'(rw[i]);
      req_age[i*AGE_W +: AGE_W] = AGE_W'(ag[i]);
    end
    for (int b = 0; b < B; b++) open_row[b*ROW_W +: ROW_W] = ROW_W'(orow[b]);
    for (int t = 0; t < T; t++) thread_rank[t*RANK_W +: RANK_W] = RANK_W'(rk[t]);
  end

  batch_req_arbiter u_batch_req_arbiter (.*);

  function automatic bit better(int i, int j);
    bit hi = rw[i] == orow[bk[i]], hj = rw[j] == orow[bk[j]];
    if (m[i] != m[j]) return m[i];
    if (hi != hj) return hi;
    if (rk[th[i]] != rk[th[j]]) return rk[th[i]] < rk[th[j]];
    if (ag[i] != ag[j]) return ag[i] < ag[j];
    return 0;
  endfunction

  function automatic int exp_win(int b);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (v[i] && bk[i] == b && (best < 0 || better(i, best))) best = i;
    return best;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      v[i] = 0; m[i] = 0; th[i] = 0; bk[i] = 0; rw[i] = 0; ag[i] = 1000 + i;
    end
    for (int b = 0; b < B; b++) orow[b] = 0;
    for (int t = 0; t < T; t++) rk[t] = t;
  endtask

  task automatic put(int i, bit mk, int t, int b, int r, int a);
    v[i] = 1; m[i] = mk; th[i] = t; bk[i] = b; rw[i] = r; ag[i] = a;
  endtask

  task automatic check_bank(string tag, int b);
    int e = exp_win(b);
    int gi = int'(grant_idx[b*IDX_W +: IDX_W]);
    checks++;
    if (e < 0) begin
      if (grant_valid[b] !== 1'b0) begin
        errors++;
        $display("FAIL %s bank %0d: valid=%b expected 0", tag, b, grant_valid[b]);
      end
    end else if (grant_valid[b] !== 1'b1 || gi != e) begin
      errors++;
      $display("FAIL %s bank %0d: valid=%b idx=%0d expected valid=1 idx=%0d",
               tag, b, grant_valid[b], gi, e);
    end
  endtask

  task automatic step_check(string tag);
    @(posedge clk); #1;
    for (int b = 0; b < B; b++) check_bank(tag, b);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_all();
    put(0, 1, 0, 0, 0, 1);
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (grant_valid !== '0) begin
      errors++;
      $display("FAIL R1 reset: valid=%b expected 0", grant_valid);
    end
    rst_n = 1;
    @(posedge clk); #1;
    checks++;
    if (grant_valid[0] !== 1'b1) begin
      errors++;
      $display("FAIL R10 first decision: valid=%b expected 1", grant_valid[0]);
    end

    clear_all();
    step_check("R3 empty buffer");

    clear_all();
    put(3, 0, 1, 2, 7, 5); put(9, 0, 2, 2, 0, 1);
    step_check("R4 unmarked only served");

    clear_all();
    put(4, 0, 0, 1, 0, 0); put(20, 1, 7, 1, 5, 900);
    step_check("R5 marked miss beats unmarked hit");

    clear_all();
    put(5, 1, 0, 3, 9, 0); put(30, 1, 7, 3, 0, 800);
    step_check("R6 hit beats top-rank miss");

    clear_all();
    rk[2] = 0; rk[5] = 1; rk[0] = 4;
    put(6, 1, 5, 0, 0, 1); put(7, 1, 2, 0, 0, 500);
    put(40, 1, 5, 4, 0, 2); put(41, 1, 2, 4, 0, 600);
    step_check("R7 rank same in banks 0 and 4");

    clear_all();
    put(10, 0, 3, 5, 1, 300); put(11, 0, 3, 5, 1, 299);
    step_check("R8 older wins");

    clear_all();
    put(50, 1, 3, 6, 0, 42); put(12, 1, 3, 6, 0, 42); put(90, 1, 3, 6, 0, 42);
    step_check("R9 lowest index on full tie");

    for (int it = 0; it < 60; it++) begin
      clear_all();
      for (int t = 0; t < T; t++) rk[t] = $urandom_range(0, 7);
      for (int b = 0; b < B; b++) orow[b] = $urandom_range(0, 3);
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 3) != 0)
          put(i, $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 3), $urandom_range(0, 40));
      step_check("R2 R5 R6 R7 R8 R9 R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule